// File: doc/BRIEF.md
# Adaptive Voltage Level Calculator

This block turns one fused voltage index for the fastest load level into voltage-table indices for all four load levels. It then programs them into a voltage controller through a simple write stream. The block holds a 52-entry millivolt table, which it computes rather than stores. The lower levels are found by taking a margin off the top level's voltage, applying a floor, and rounding the result up to the nearest table entry. The search runs serially, one table entry per clock.

A boot sequencer pulses `start` with the fused index and a code for the base clock frequency. The engine runs up to three searches and applies the frequency-dependent minimum for level 1. It then emits six writes in a fixed order: disable the controller, enable low-voltage mode, program three voltage-set registers, and re-enable the controller. When the last write is accepted, `done` pulses. An out-of-range fused index skips all of this, raises `error` and pulses `done`.

Top module: `avs_level_calc`

## Requirements
- R1: Table entry i (0..51) has voltage 747 + floor(35*i/3) mV. A match for target T is the lowest i whose voltage is at least T, or 51 if none qualifies. The search examines one entry per clock.
- R2: If `lvl0In` is 52 or more when start is taken, `error` is set, `done` pulses on the next cycle, no write is issued, and the four index outputs keep their previous values.
- R3: If the level 0 voltage is at most 1000 mV and `clsIn` is 0 (600/800 MHz), `lvlIdx0` equals the fused index and levels 1..3 equal the match for 1000 mV (index 22).
- R4: If the level 0 voltage is at most 1000 mV and `clsIn` is 1 (1000 MHz), levels 0 and 1 become the match for 1108 mV (31). If `clsIn` is 2 or 3 (1200 MHz), levels 0 and 1 become the match for 1155 mV (35). Levels 2 and 3 stay 22.
- R5: Otherwise `lvlIdx0` is the fused index. Level 1 is the match for max(V0-100, 1000). Levels 2 and 3 are the match for max(V0-150, 1000).
- R6: On the path of R5 with `clsIn` nonzero, a floor equals the match for 1108 mV (class 1) or 1155 mV (class 2/3), capped at the fused index. Level 1 is raised to the floor if it is below it.
- R7: Six writes in this order:
  - address 0x00 with data 0 (enable bit 30 cleared);
  - address 0x08 with data bit 6 set;
  - addresses 0x1C, 0x20 and 0x24, carrying the level 1, 2 and 3 index in both bits 21:16 and bits 27:22;
  - address 0x00 with data bit 30 set.
- R8: While `wrValid` is high and `wrReady` low, `wrValid`, `wrAddr` and `wrData` hold.
- R9: `done` is high for exactly one cycle, the cycle after the last write is accepted. `error` clears when a valid start is taken.
- R10: A start pulse while the engine is busy is ignored. The running computation and its writes are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (taken only when idle) |
| lvl0In | input | 6 | Fused level 0 table index |
| clsIn | input | 2 | Frequency class: 0 = 600/800, 1 = 1000, 2/3 = 1200 MHz |
| wrReady | input | 1 | Write target accepts the current write |
| lvlIdx0 | output | 6 | Level 0 index |
| lvlIdx1 | output | 6 | Level 1 index |
| lvlIdx2 | output | 6 | Level 2 index |
| lvlIdx3 | output | 6 | Level 3 index |
| error | output | 1 | Fused index out of range |
| done | output | 1 | One-cycle completion pulse |
| wrAddr | output | 8 | Write byte address |
| wrData | output | 32 | Write data |
| wrValid | output | 1 | Write request |

## Verification
Some properties are checked by assertions on every cycle:
- the search pointer stays inside the table;
- a stalled write holds its address and data;
- `done` lasts one cycle;
- no write appears alongside `error`;
- at completion, levels 2 and 3 are equal and level 1 is not below them.

Other behaviour can only be shown by the bench's scenarios: the exact index values in each path, the write order and formats, the done timing, and that a start pulse while busy is ignored. The bench compares each accepted write with a behavioural model under a varying ready pattern.

// File: rtl/avs_calc_pkg.sv
`timescale 1ns/1ps
package avs_calc_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic       load;    // capture inputs, clear search pointer
    logic       step;    // advance search by one entry
    logic       commit;  // store current search result
    logic [1:0] sel;     // which search (0: level 1, 1: levels 2/3, 2: floor)
    logic [2:0] wrSeq;   // position in the write sequence
  } avs_ctl_t;

  // Millivolts of table entry i
  function automatic logic [10:0] idxToMv(input logic [5:0] i);
    int unsigned v;
    v = 747 + (35 * int'(i)) / 3;
    return v[10:0];
  endfunction

endpackage

// File: rtl/avs_calc_dp.sv
`timescale 1ns/1ps
module avs_calc_dp
  import avs_calc_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int TABLE_N = 52,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  avs_ctl_t          ctl,
  input  logic [IDX_W-1:0]  lvl0In,
  input  logic [1:0]        clsIn,
  output logic              srchHit,
  output logic              fastCls,
  output logic              lvl0Bad,
  output logic [IDX_W-1:0]  lvlIdx [4],
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam int MV_W        = 11;
  localparam int LAST_IDX    = TABLE_N - 1;
  localparam int FLOOR_MV    = 1000;
  localparam int MARGIN_L1   = 100;
  localparam int MARGIN_L23  = 150;
  localparam int MIN_1000    = 1108;
  localparam int MIN_1200    = 1155;
  localparam int SET_BASE    = 'h1C;
  localparam int LOWV_ADDR   = 'h08;
  localparam int HI_POS      = 16;
  localparam int LO_POS      = 22;
  localparam int LOWV_BIT    = 6;
  localparam int EN_BIT      = 30;

  logic [IDX_W-1:0] baseIdx, srchIdx;
  logic [1:0]       clsReg;
  logic [IDX_W-1:0] idxQ [4];
  logic [MV_W-1:0]  v0, tgtL1, tgtL23, tgtFloor, target, curMv;
  logic             lowPath;
  logic [IDX_W-1:0] capped;

  assign lvl0Bad = int'(lvl0In) >= TABLE_N;
  assign fastCls = clsReg != 2'd0;
  assign v0      = idxToMv(baseIdx);
  assign lowPath = int'(v0) <= FLOOR_MV;

  always_comb begin
    if (lowPath || (int'(v0) - MARGIN_L1) < FLOOR_MV) tgtL1 = MV_W'(FLOOR_MV);
    else                                               tgtL1 = v0 - MV_W'(MARGIN_L1);
    if (lowPath || (int'(v0) - MARGIN_L23) < FLOOR_MV) tgtL23 = MV_W'(FLOOR_MV);
    else                                                tgtL23 = v0 - MV_W'(MARGIN_L23);
    tgtFloor = (clsReg >= 2'd2) ? MV_W'(MIN_1200) : MV_W'(MIN_1000);
    case (ctl.sel)
      2'd0:    target = tgtL1;
      2'd1:    target = tgtL23;
      default: target = tgtFloor;
    endcase
  end

  assign curMv   = idxToMv(srchIdx);
  assign srchHit = (curMv >= target) || (int'(srchIdx) == LAST_IDX);
  assign capped  = (srchIdx < baseIdx) ? srchIdx : baseIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseIdx <= '0;
      clsReg  <= '0;
      srchIdx <= '0;
      for (int i = 0; i < 4; i++) idxQ[i] <= '0;
    end else begin
      if (ctl.load) begin
        baseIdx <= lvl0In;
        clsReg  <= clsIn;
        idxQ[0] <= lvl0In;
        srchIdx <= '0;
      end
      if (ctl.step) srchIdx <= srchHit ? '0 : srchIdx + 1'b1;
      if (ctl.commit) begin
        case (ctl.sel)
          2'd0: idxQ[1] <= srchIdx;
          2'd1: begin
            idxQ[2] <= srchIdx;
            idxQ[3] <= srchIdx;
          end
          default: begin
            if (lowPath) begin
              idxQ[0] <= srchIdx;
              idxQ[1] <= srchIdx;
            end else if (idxQ[1] < capped) begin
              idxQ[1] <= capped;
            end
          end
        endcase
      end
    end
  end

  assign lvlIdx = idxQ;

  // Write formatter
  always_comb begin
    wrAddr = '0;
    wrData = '0;
    case (ctl.wrSeq)
      3'd0: ;
      3'd1: begin
        wrAddr = ADDR_W'(LOWV_ADDR);
        wrData[LOWV_BIT] = 1'b1;
      end
      3'd2, 3'd3, 3'd4: begin
        wrAddr = ADDR_W'(SET_BASE + 4 * (int'(ctl.wrSeq) - 2));
        wrData[HI_POS +: IDX_W] = idxQ[int'(ctl.wrSeq) - 1];
        wrData[LO_POS +: IDX_W] = idxQ[int'(ctl.wrSeq) - 1];
      end
      default: wrData[EN_BIT] = 1'b1;
    endcase
  end

  a_r1_search_in_table: assert property (@(posedge clk) disable iff (!rstN)
    int'(srchIdx) < TABLE_N);

  a_r1_one_entry_per_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step && !srchHit |=> srchIdx == $past(srchIdx) + 1'b1);

endmodule

// File: rtl/avs_calc_ctrl.sv
`timescale 1ns/1ps
module avs_calc_ctrl
  import avs_calc_pkg::*;
#(
  parameter int N_WRITES = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     srchHit,
  input  logic     fastCls,
  input  logic     lvl0Bad,
  input  logic     wrReady,
  output avs_ctl_t ctl,
  output logic     wrValid,
  output logic     done,
  output logic     error
);
  localparam logic [2:0] LAST_WR = 3'(N_WRITES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SRCH, ST_WRITE, ST_FIN} state_t;
  state_t     state;
  logic [1:0] selQ;
  logic [2:0] seqQ;
  logic       errQ;
  logic       lastSearch;

  assign lastSearch = (selQ == 2'd2) || (selQ == 2'd1 && !fastCls);

  always_comb begin
    ctl        = '0;
    ctl.load   = (state == ST_IDLE) && start && !lvl0Bad;
    ctl.step   = (state == ST_SRCH);
    ctl.commit = (state == ST_SRCH) && srchHit;
    ctl.sel    = selQ;
    ctl.wrSeq  = seqQ;
  end

  assign wrValid = (state == ST_WRITE);
  assign done    = (state == ST_FIN);
  assign error   = errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      selQ  <= '0;
      seqQ  <= '0;
      errQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          if (lvl0Bad) begin
            errQ  <= 1'b1;
            state <= ST_FIN;
          end else begin
            errQ  <= 1'b0;
            selQ  <= '0;
            state <= ST_SRCH;
          end
        end
        ST_SRCH: if (srchHit) begin
          if (lastSearch) begin
            seqQ  <= '0;
            state <= ST_WRITE;
          end else begin
            selQ <= selQ + 1'b1;
          end
        end
        ST_WRITE: if (wrReady) begin
          if (seqQ == LAST_WR) state <= ST_FIN;
          else                 seqQ  <= seqQ + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r2_no_write_on_error: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !wrValid);

  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SRCH) && start && !srchHit |=> state == ST_SRCH);

endmodule

// File: rtl/avs_level_calc.sv
`timescale 1ns/1ps
module avs_level_calc
  import avs_calc_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int TABLE_N = 52,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  lvl0In,
  input  logic [1:0]        clsIn,
  input  logic              wrReady,
  output logic [IDX_W-1:0]  lvlIdx0,
  output logic [IDX_W-1:0]  lvlIdx1,
  output logic [IDX_W-1:0]  lvlIdx2,
  output logic [IDX_W-1:0]  lvlIdx3,
  output logic              error,
  output logic              done,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid
);
  avs_ctl_t         ctl;
  logic             srchHit, fastCls, lvl0Bad;
  logic [IDX_W-1:0] lvlIdx [4];

  avs_calc_ctrl #(.N_WRITES(6)) u_ctrl (
    .clk, .rstN, .start, .srchHit, .fastCls, .lvl0Bad, .wrReady,
    .ctl, .wrValid, .done, .error
  );

  avs_calc_dp #(.IDX_W(IDX_W), .TABLE_N(TABLE_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk, .rstN, .ctl, .lvl0In, .clsIn, .srchHit, .fastCls, .lvl0Bad,
    .lvlIdx, .wrAddr, .wrData
  );

  assign lvlIdx0 = lvlIdx[0];
  assign lvlIdx1 = lvlIdx[1];
  assign lvlIdx2 = lvlIdx[2];
  assign lvlIdx3 = lvlIdx[3];

  a_r8_write_held: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData));

  a_r5_level_order: assert property (@(posedge clk) disable iff (!rstN)
    done && !error |-> (lvlIdx2 == lvlIdx3) && (lvlIdx1 >= lvlIdx2)
                       && (int'(lvlIdx1) < TABLE_N));

endmodule

// File: tb/tb_avs_level_calc.sv
`timescale 1ns/1ps
module tb_avs_level_calc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  lvl0In = '0;
  logic [1:0]  clsIn = '0;
  logic        wrReady = 1'b1;
  logic [5:0]  lvlIdx0, lvlIdx1, lvlIdx2, lvlIdx3;
  logic        error, done, wrValid;
  logic [7:0]  wrAddr;
  logic [31:0] wrData;

  avs_level_calc dut (.*);

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0, cyc = 0, lastWrCyc = 0;
  logic [7:0]  expAddrQ [$];
  logic [31:0] expDataQ [$];
  int  expIdx [4] = '{0, 0, 0, 0};
  bit  expErr = 0, doneSeen = 0, readyMode = 0;
  logic [7:0] lfsr = 8'hA5;
  string curTag = "R0";

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mvOf(int i);
    return 747 + (35 * i) / 3;
  endfunction

  function automatic int matchOf(int t);
    for (int i = 0; i < 52; i++) if (mvOf(i) >= t) return i;
    return 51;
  endfunction

  function automatic logic [31:0] setWord(int idx);
    return (32'(idx) << 16) | (32'(idx) << 22);
  endfunction

  task automatic buildExp(int l0, int cls);
    int v0, fl;
    if (l0 >= 52) begin
      expErr = 1;
      return;
    end
    expErr = 0;
    v0 = mvOf(l0);
    expIdx[0] = l0;
    if (v0 <= 1000) begin
      expIdx[1] = matchOf(1000);
      expIdx[2] = expIdx[1];
      expIdx[3] = expIdx[1];
      if (cls != 0) begin
        fl = matchOf(cls == 1 ? 1108 : 1155);
        expIdx[0] = fl;
        expIdx[1] = fl;
      end
    end else begin
      expIdx[1] = matchOf((v0 - 100) > 1000 ? v0 - 100 : 1000);
      expIdx[2] = matchOf((v0 - 150) > 1000 ? v0 - 150 : 1000);
      expIdx[3] = expIdx[2];
      if (cls != 0) begin
        fl = matchOf(cls == 1 ? 1108 : 1155);
        if (fl > l0) fl = l0;
        if (expIdx[1] < fl) expIdx[1] = fl;
      end
    end
    expAddrQ.push_back(8'h00); expDataQ.push_back(32'h0);
    expAddrQ.push_back(8'h08); expDataQ.push_back(32'h40);
    for (int k = 1; k <= 3; k++) begin
      expAddrQ.push_back(8'(8'h1C + 4 * (k - 1)));
      expDataQ.push_back(setWord(expIdx[k]));
    end
    expAddrQ.push_back(8'h00); expDataQ.push_back(32'h4000_0000);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wrReady = readyMode ? lfsr[0] : 1'b1;
  end

  // per-clock comparison against the model
  always @(negedge clk) if (rstN) begin
    if (wrValid && wrReady) begin
      if (expAddrQ.size() == 0) begin
        chk(0, "R7", "unexpected write addr", wrAddr, 0);
      end else begin
        logic [7:0] ea; logic [31:0] ed;
        ea = expAddrQ.pop_front();
        ed = expDataQ.pop_front();
        chk(wrAddr == ea, "R7", {curTag, " write addr"}, wrAddr, ea);
        chk(wrData == ed, "R7", {curTag, " write data"}, wrData, ed);
        lastWrCyc = cyc;
      end
    end
    if (done) begin
      doneSeen = 1;
      chk(error == expErr, "R2", {curTag, " error flag"}, error, expErr);
      chk(expAddrQ.size() == 0, "R7", {curTag, " writes left at done"}, expAddrQ.size(), 0);
      if (!expErr) chk(cyc == lastWrCyc + 1, "R9", "done timing", cyc, lastWrCyc + 1);
      chk(lvlIdx0 == expIdx[0], curTag, "lvlIdx0", lvlIdx0, expIdx[0]);
      chk(lvlIdx1 == expIdx[1], curTag, "lvlIdx1", lvlIdx1, expIdx[1]);
      chk(lvlIdx2 == expIdx[2], curTag, "lvlIdx2", lvlIdx2, expIdx[2]);
      chk(lvlIdx3 == expIdx[3], curTag, "lvlIdx3", lvlIdx3, expIdx[3]);
    end
  end

  task automatic runOne(int l0, int cls, string tag, bit poke);
    int waitCyc;
    curTag = tag;
    doneSeen = 0;
    @(posedge clk); #1;
    start = 1; lvl0In = 6'(l0); clsIn = 2'(cls);
    buildExp(l0, cls);
    @(posedge clk); #1;
    start = 0;
    if (poke) begin
      repeat (4) @(posedge clk);
      #1; start = 1; lvl0In = 6'd5; clsIn = 2'd0;   // R10: ignored while busy
      @(posedge clk); #1; start = 0;
    end
    waitCyc = 0;
    while (!doneSeen && waitCyc < 2000) begin
      @(posedge clk);
      waitCyc++;
    end
    chk(doneSeen, "R9", {tag, " watchdog: done never seen"}, 0, 1);
    @(posedge clk); #1;
    chk(done == 1'b0, "R9", "done lasts one cycle", done, 0);
    expAddrQ.delete();
    expDataQ.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(done == 0 && wrValid == 0 && error == 0, "R9", "reset outputs", {done, wrValid, error}, 0);
    chk(lvlIdx1 == 0, "R3", "reset index", lvlIdx1, 0);
    runOne(10, 0, "R3", 0);
    runOne(10, 1, "R4", 0);
    runOne(21, 2, "R4", 0);
    runOne(40, 0, "R5", 0);
    runOne(40, 1, "R6", 0);
    runOne(40, 2, "R6", 0);
    runOne(33, 3, "R6", 0);
    runOne(51, 1, "R5", 0);
    runOne(22, 1, "R1", 0);
    runOne(52, 1, "R2", 0);          // indices keep prior values
    runOne(63, 0, "R2", 0);
    runOne(45, 0, "R5", 0);          // R9: error cleared by a valid start
    runOne(45, 2, "R10", 1);
    readyMode = 1;
    runOne(47, 1, "R8", 0);
    runOne(0, 0, "R1", 0);
    runOne(30, 2, "R8", 0);
    readyMode = 0;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5 * 190000);
    nChecks++; nFails++;
    $display("FAIL R9 global watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule